// File: doc/BRIEF.md
# Legacy System Control Port Bank

This block answers a small set of byte-wide legacy platform control addresses on a simple bus with an address, write data, a write strobe and a read strobe. It holds one writable system control byte, two password-protect lock bits that flip on every write to their own addresses, and three sticky request flags. Software can ask for a soft reset, a little-endian mode switch or a non-contiguous I/O map. The block raises these requests as flags and does not act on them. Surrounding logic decides what to do about each request.

Reads return either the stored control byte or a fixed status code: equipment present, keylock, cache status, I/O map type, and the value of the special port. Every address the block does not decode reads as all ones. Read data is registered. It appears on the cycle after the read strobe and holds until the next read. The lock bits, the control byte and the request flags are the block's only other outputs.

Top module: `sysport_bank`

## Requirements
- R1: A synchronous active-high reset clears the control byte, both lock bits, all three request flags and the read data output to zero.
- R2: A write to address 0x0092 with data bit 7 set raises req_soft_reset. A write there with data bit 6 set raises req_le_mode. A write with both bits set raises both flags.
- R3: Every write to 0x0810 inverts lock[0], and every write to 0x0812 inverts lock[1], whatever the data value.
- R4: A write to 0x081C stores the data byte on ctrl_byte, and a read of 0x081C returns it. A read and a write to 0x081C in the same cycle return the value held before that write.
- R5: Reads return fixed codes: 0x0092 gives 0x40, 0x080C gives 0xFC, 0x0818 gives 0x00, 0x0823 gives 0x03, and 0x0850 gives 0x00.
- R6: A write to 0x0850 with data bit 7 set raises req_io_map. Bits 6 to 0 of that write have no effect.
- R7: A read of any address outside the set in R4 and R5 returns 0xFF. This includes the lock addresses, the edges of the 0x0800 to 0x0851 window, and addresses outside that window.
- R8: Writes to 0x0808, 0x0814, read-only addresses and undecoded addresses leave ctrl_byte, lock and all request flags unchanged, and leave the fixed read codes unchanged.
- R9: rdata takes its new value on the clock edge at which rd_en is sampled high. It holds its value on every cycle with rd_en low, whatever the address.
- R10: Once raised, each request flag stays high until reset. Later writes with the trigger bit clear do not lower it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Port address |
| wdata | input | 8 | Write data byte |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| rdata | output | 8 | Registered read data |
| ctrl_byte | output | 8 | Stored system control byte |
| lock | output | 2 | Password-protect lock bits |
| req_soft_reset | output | 1 | Sticky soft-reset request |
| req_le_mode | output | 1 | Sticky little-endian mode request |
| req_io_map | output | 1 | Sticky non-contiguous I/O map request |

## Verification
The special port is written with data 0x00, 0x40, 0x80 and 0xC0. These values show that each request flag follows its own bit and that a later write with the bits clear cannot lower a flag. Each lock address is written once with all zeros and once with all ones, which shows that the data value plays no part in the toggle. The control byte is stored with two complementary patterns, and a read and a write to it are issued in the same cycle to show the read returns the value held before the write. Undecoded reads are taken at the window edges, at the lock addresses and at a far address. Writes to ignored addresses use 0xFF, so that any leak into the state would be visible.

// File: rtl/sysport_pkg.sv
package sysport_pkg;

    localparam int unsigned PORT_AW = 16;
    localparam int unsigned BYTE_W  = 8;

    // decoded port addresses
    localparam logic [PORT_AW-1:0] A_SPECIAL   = 16'h0092;
    localparam logic [PORT_AW-1:0] A_DISKLIGHT = 16'h0808;
    localparam logic [PORT_AW-1:0] A_EQUIP     = 16'h080C;
    localparam logic [PORT_AW-1:0] A_LOCK0     = 16'h0810;
    localparam logic [PORT_AW-1:0] A_LOCK1     = 16'h0812;
    localparam logic [PORT_AW-1:0] A_CACHEINV  = 16'h0814;
    localparam logic [PORT_AW-1:0] A_KEYLOCK   = 16'h0818;
    localparam logic [PORT_AW-1:0] A_SYSCTRL   = 16'h081C;
    localparam logic [PORT_AW-1:0] A_CACHEST   = 16'h0823;
    localparam logic [PORT_AW-1:0] A_MAPTYPE   = 16'h0850;

    // fixed read codes
    localparam logic [BYTE_W-1:0] RD_SPECIAL = 8'h40;
    localparam logic [BYTE_W-1:0] RD_EQUIP   = 8'hFC;
    localparam logic [BYTE_W-1:0] RD_KEYLOCK = 8'h00;
    localparam logic [BYTE_W-1:0] RD_CACHEST = 8'h03;
    localparam logic [BYTE_W-1:0] RD_MAPTYPE = 8'h00;
    localparam logic [BYTE_W-1:0] RD_FLOAT   = 8'hFF;

    // trigger bit positions inside write data
    localparam int unsigned BIT_SOFTRST = 7;
    localparam int unsigned BIT_LEMODE  = 6;
    localparam int unsigned BIT_IOMAP   = 7;

    localparam int unsigned N_LOCK = 2;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_SPECIAL,
        SEL_DISKLIGHT,
        SEL_EQUIP,
        SEL_LOCK0,
        SEL_LOCK1,
        SEL_CACHEINV,
        SEL_KEYLOCK,
        SEL_SYSCTRL,
        SEL_CACHEST,
        SEL_MAPTYPE
    } port_sel_e;

    typedef struct packed {
        logic [N_LOCK-1:0] lock_flip;
        logic              ctrl_load;
        logic              set_softrst;
        logic              set_lemode;
        logic              set_iomap;
    } wr_effect_t;

    typedef struct packed {
        logic softrst;
        logic lemode;
        logic iomap;
    } req_flags_t;

    function automatic port_sel_e decode_port(input logic [PORT_AW-1:0] a);
        port_sel_e s;
        unique case (a)
            A_SPECIAL:   s = SEL_SPECIAL;
            A_DISKLIGHT: s = SEL_DISKLIGHT;
            A_EQUIP:     s = SEL_EQUIP;
            A_LOCK0:     s = SEL_LOCK0;
            A_LOCK1:     s = SEL_LOCK1;
            A_CACHEINV:  s = SEL_CACHEINV;
            A_KEYLOCK:   s = SEL_KEYLOCK;
            A_SYSCTRL:   s = SEL_SYSCTRL;
            A_CACHEST:   s = SEL_CACHEST;
            A_MAPTYPE:   s = SEL_MAPTYPE;
            default:     s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [BYTE_W-1:0] read_value(input port_sel_e s,
                                                     input logic [BYTE_W-1:0] ctrl);
        logic [BYTE_W-1:0] v;
        case (s)
            SEL_SPECIAL: v = RD_SPECIAL;
            SEL_EQUIP:   v = RD_EQUIP;
            SEL_KEYLOCK: v = RD_KEYLOCK;
            SEL_SYSCTRL: v = ctrl;
            SEL_CACHEST: v = RD_CACHEST;
            SEL_MAPTYPE: v = RD_MAPTYPE;
            default:     v = RD_FLOAT;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/sysport_decode.sv
module sysport_decode
    import sysport_pkg::*;
#(
    parameter int unsigned ADDR_W = PORT_AW,
    parameter int unsigned DATA_W = BYTE_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    output port_sel_e         sel,
    output wr_effect_t        eff
);
    localparam int unsigned CMP_W = (ADDR_W > PORT_AW) ? ADDR_W : PORT_AW;

    logic [CMP_W-1:0] addr_ext;
    logic             high_clear;

    always_comb begin
        addr_ext   = CMP_W'(addr);
        high_clear = (addr_ext >> PORT_AW) == '0;
        sel        = high_clear ? decode_port(addr_ext[PORT_AW-1:0]) : SEL_NONE;
    end

    logic [N_LOCK-1:0] lock_hit;
    assign lock_hit[0] = (sel == SEL_LOCK0);
    assign lock_hit[1] = (sel == SEL_LOCK1);

    always_comb begin
        eff             = '0;
        eff.lock_flip   = wr_en ? lock_hit : '0;
        eff.ctrl_load   = wr_en && (sel == SEL_SYSCTRL);
        eff.set_softrst = wr_en && (sel == SEL_SPECIAL) && wdata[BIT_SOFTRST];
        eff.set_lemode  = wr_en && (sel == SEL_SPECIAL) && wdata[BIT_LEMODE];
        eff.set_iomap   = wr_en && (sel == SEL_MAPTYPE) && wdata[BIT_IOMAP];
    end
endmodule

// File: rtl/sysport_regs.sv
module sysport_regs
    import sysport_pkg::*;
#(
    parameter int unsigned DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_effect_t        eff,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [N_LOCK-1:0] lock_q,
    output req_flags_t        req_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (eff.ctrl_load) begin
            ctrl_q <= wdata;
        end
    end

    for (genvar g = 0; g < N_LOCK; g++) begin : g_lock
        always_ff @(posedge clk) begin
            if (rst) begin
                lock_q[g] <= 1'b0;
            end else if (eff.lock_flip[g]) begin
                lock_q[g] <= ~lock_q[g];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else begin
            req_q.softrst <= req_q.softrst | eff.set_softrst;
            req_q.lemode  <= req_q.lemode  | eff.set_lemode;
            req_q.iomap   <= req_q.iomap   | eff.set_iomap;
        end
    end
endmodule

// File: rtl/sysport_rdpath.sv
module sysport_rdpath
    import sysport_pkg::*;
#(
    parameter int unsigned DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  port_sel_e         sel,
    input  logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] rd_next;

    always_comb begin
        rd_next = DATA_W'(read_value(sel, BYTE_W'(ctrl_q)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_next;
        end
    end
endmodule

// File: rtl/sysport_bank.sv
module sysport_bank
    import sysport_pkg::*;
#(
    parameter int unsigned ADDR_W = PORT_AW,
    parameter int unsigned DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] ctrl_byte,
    output logic [N_LOCK-1:0] lock,
    output logic              req_soft_reset,
    output logic              req_le_mode,
    output logic              req_io_map
);
    port_sel_e  sel;
    wr_effect_t eff;
    req_flags_t req_q;

    sysport_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .addr  (addr),
        .wdata (wdata),
        .wr_en (wr_en),
        .sel   (sel),
        .eff   (eff)
    );

    sysport_regs #(.DATA_W(DATA_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .eff    (eff),
        .wdata  (wdata),
        .ctrl_q (ctrl_byte),
        .lock_q (lock),
        .req_q  (req_q)
    );

    sysport_rdpath #(.DATA_W(DATA_W)) u_rd (
        .clk    (clk),
        .rst    (rst),
        .rd_en  (rd_en),
        .sel    (sel),
        .ctrl_q (ctrl_byte),
        .rdata  (rdata)
    );

    assign req_soft_reset = req_q.softrst;
    assign req_le_mode    = req_q.lemode;
    assign req_io_map     = req_q.iomap;
endmodule

// File: rtl/sysport_chk.sv
module sysport_chk #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] rdata,
    input logic [DATA_W-1:0] ctrl_byte,
    input logic [1:0]        lock,
    input logic              req_soft_reset,
    input logic              req_le_mode,
    input logic              req_io_map
);
    logic readable;
    always_comb begin
        readable = (addr == ADDR_W'(16'h0092)) || (addr == ADDR_W'(16'h080C)) ||
                   (addr == ADDR_W'(16'h0818)) || (addr == ADDR_W'(16'h081C)) ||
                   (addr == ADDR_W'(16'h0823)) || (addr == ADDR_W'(16'h0850));
    end

    // R1
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (ctrl_byte == '0 && lock == '0 && !req_soft_reset &&
                 !req_le_mode && !req_io_map && rdata == '0));

    p_soft_req_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(16'h0092) && wdata[7]) |=> req_soft_reset);

    p_le_req_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(16'h0092) && wdata[6]) |=> req_le_mode);

    p_lock0_flip_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(16'h0810)) |=> (lock[0] != $past(lock[0])));

    p_lock1_flip_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(16'h0812)) |=> (lock[1] != $past(lock[1])));

    p_ctrl_store_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(16'h081C)) |=> (ctrl_byte == $past(wdata)));

    p_map_req_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(16'h0850) && wdata[7]) |=> req_io_map);

    p_float_read_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !readable) |=> (rdata == {DATA_W{1'b1}}));

    p_ctrl_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == ADDR_W'(16'h081C)) |=> $stable(ctrl_byte));

    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

    p_soft_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        req_soft_reset |=> req_soft_reset);

    p_le_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        req_le_mode |=> req_le_mode);

    p_map_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        req_io_map |=> req_io_map);
endmodule

bind sysport_bank sysport_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .addr           (addr),
    .wdata          (wdata),
    .wr_en          (wr_en),
    .rd_en          (rd_en),
    .rdata          (rdata),
    .ctrl_byte      (ctrl_byte),
    .lock           (lock),
    .req_soft_reset (req_soft_reset),
    .req_le_mode    (req_le_mode),
    .req_io_map     (req_io_map)
);

// File: tb/sim_sysport_bank.sv
`timescale 1ns/1ps
module sim_sysport_bank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rdata;
    logic [7:0]  ctrl_byte;
    logic [1:0]  lock;
    logic        req_soft_reset, req_le_mode, req_io_map;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    sysport_bank u0 (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_en(rd_en), .rdata(rdata), .ctrl_byte(ctrl_byte), .lock(lock),
        .req_soft_reset(req_soft_reset), .req_le_mode(req_le_mode),
        .req_io_map(req_io_map)
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] reqs();
        return {5'b0, req_soft_reset, req_le_mode, req_io_map};
    endfunction

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "rdata", rdata, 8'h00);
        chk("R1", "ctrl_byte", ctrl_byte, 8'h00);
        chk("R1", "lock", {6'b0, lock}, 8'h00);
        chk("R1", "requests", reqs(), 8'h00);
    endtask

    task automatic t_fixed_reads();
        logic [7:0] v;
        rd(16'h0092, v); chk("R5", "read 0092", v, 8'h40);
        rd(16'h080C, v); chk("R5", "read 080C", v, 8'hFC);
        rd(16'h0818, v); chk("R5", "read 0818", v, 8'h00);
        rd(16'h0823, v); chk("R5", "read 0823", v, 8'h03);
        rd(16'h0850, v); chk("R5", "read 0850", v, 8'h00);
    endtask

    task automatic t_float_reads();
        logic [7:0] v;
        rd(16'h0800, v); chk("R7", "read 0800", v, 8'hFF);
        rd(16'h0851, v); chk("R7", "read 0851", v, 8'hFF);
        rd(16'h0810, v); chk("R7", "read 0810", v, 8'hFF);
        rd(16'h0812, v); chk("R7", "read 0812", v, 8'hFF);
        rd(16'h1234, v); chk("R7", "read 1234", v, 8'hFF);
    endtask

    task automatic t_ctrl();
        logic [7:0] v;
        wr(16'h081C, 8'hA5);
        chk("R4", "ctrl_byte after A5", ctrl_byte, 8'hA5);
        rd(16'h081C, v); chk("R4", "read ctrl A5", v, 8'hA5);
        wr(16'h081C, 8'h5A);
        rd(16'h081C, v); chk("R4", "read ctrl 5A", v, 8'h5A);
        // read and write in the same cycle: old value returned
        @(negedge clk);
        addr = 16'h081C; wdata = 8'h3C; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R4", "same-cycle read", rdata, 8'h5A);
        chk("R4", "same-cycle store", ctrl_byte, 8'h3C);
    endtask

    task automatic t_locks();
        wr(16'h0810, 8'h00); chk("R3", "lock after 0810/00", {6'b0, lock}, 8'h01);
        wr(16'h0812, 8'hFF); chk("R3", "lock after 0812/FF", {6'b0, lock}, 8'h03);
        wr(16'h0810, 8'hFF); chk("R3", "lock after 0810/FF", {6'b0, lock}, 8'h02);
        wr(16'h0812, 8'h00); chk("R3", "lock after 0812/00", {6'b0, lock}, 8'h00);
    endtask

    task automatic t_ignored();
        logic [7:0] v;
        wr(16'h0810, 8'h00); // lock = 01 as a marker
        wr(16'h0808, 8'hFF);
        wr(16'h0814, 8'hFF);
        wr(16'h080C, 8'hFF);
        wr(16'h0823, 8'hFF);
        wr(16'h0800, 8'hFF);
        wr(16'h4000, 8'hFF);
        chk("R8", "ctrl_byte", ctrl_byte, 8'h3C);
        chk("R8", "lock", {6'b0, lock}, 8'h01);
        chk("R8", "requests", reqs(), 8'h00);
        rd(16'h080C, v); chk("R8", "read 080C", v, 8'hFC);
        rd(16'h0823, v); chk("R8", "read 0823", v, 8'h03);
    endtask

    task automatic t_requests();
        wr(16'h0092, 8'h3F); chk("R2", "no trigger bits", reqs(), 8'h00);
        wr(16'h0092, 8'h40); chk("R2", "le bit", reqs(), 8'h02);
        wr(16'h0092, 8'h80); chk("R2", "soft bit", reqs(), 8'h06);
        wr(16'h0850, 8'h7F); chk("R6", "map low bits", reqs(), 8'h06);
        wr(16'h0850, 8'h80); chk("R6", "map bit", reqs(), 8'h07);
        wr(16'h0092, 8'h00);
        wr(16'h0850, 8'h00);
        chk("R10", "flags sticky", reqs(), 8'h07);
        do_reset();
        chk("R1", "requests cleared", reqs(), 8'h00);
        wr(16'h0092, 8'hC0); chk("R2", "both bits", reqs(), 8'h06);
    endtask

    task automatic t_hold();
        logic [7:0] v;
        rd(16'h080C, v);
        @(negedge clk); addr = 16'h0092;
        @(negedge clk); addr = 16'h9999;
        @(negedge clk);
        chk("R9", "rdata held", rdata, 8'hFC);
        @(negedge clk); addr = 16'h0823; rd_en = 1'b1;
        @(posedge clk); #1;
        chk("R9", "rdata at read edge", rdata, 8'h03);
        @(negedge clk); rd_en = 1'b0;
    endtask

    initial begin
        t_reset();
        t_fixed_reads();
        t_float_reads();
        t_ctrl();
        t_locks();
        t_ignored();
        t_requests();
        t_hold();
        t_reset();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R9 watchdog: actual=timeout expected=complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule